// File: doc/BRIEF.md
# Multi-Width ALU with Condition-Code Generation

This block performs one integer operation per cycle on operands of 8, 16 or 32 bits and produces the result together with four condition flags. The flags are negative, zero, overflow and carry, packed into a condition-code byte. It covers addition, subtraction, negation, comparison, increment, decrement and the bitwise AND, OR, XOR and NOT. The operation code selects the operation and a size code selects the width. The caller also supplies the current condition-code byte, so that operations which keep the carry flag can pass it through.

The outputs are registered and appear one cycle after a valid request. A write-enable output tells the surrounding datapath whether the result must be stored. It is low for a comparison, which only updates the flags, and low for any code outside the defined set. Operand bits above the selected width have no effect, and the result is zero-extended to the full data width. The register file and operand fetch sit outside this block.

Top module: `alu_ccgen`

## Requirements
- R1: Condition-code layout: `ccr_out[3]` is N, `ccr_out[2]` is Z, `ccr_out[1]` is V and `ccr_out[0]` is C. Bits [7:4] are copied from `ccr_in`. For every defined operation, N is the top bit of the result at the selected width, and Z is set exactly when the result at that width is zero.
- R2: Add (op 0) gives `opa+opb`. C is the carry out of the selected width, for example bit 16 of the sum at 16 bits. V is set when both operands have the same sign and the result sign differs from it.
- R3: Subtract (op 1) gives `opa-opb`. C is set on an unsigned borrow (`opa<opb` at the width). V is set when the operand signs differ and the result sign differs from `opa`.
- R4: Negate (op 2) gives `0-opa`. V is set exactly when `opa` is the most negative value of the width. C is set exactly when `opa` is non-zero.
- R5: Compare (op 3) produces the flags and result of subtract but drives `wr_en` low.
- R6: Increment (op 4) gives `opa+1`. V is set exactly when `opa` is the largest positive value of the width (0x7F at 8 bits). C is copied from `ccr_in[0]`.
- R7: Decrement (op 5) gives `opa-1`. V is set exactly when `opa` is the most negative value of the width. C is copied from `ccr_in[0]`.
- R8: AND (op 6), OR (op 7), XOR (op 8) and NOT of `opa` (op 9) set N and Z from the result, clear V, and copy C from `ccr_in[0]`.
- R9: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the width are ignored and result bits above it are zero. The unary operations (2, 4, 5, 9) ignore `opb`.
- R10: The outputs are valid in the cycle after `in_valid` is sampled high, with `out_valid` high. `out_valid` and `wr_en` are low in any cycle that follows an edge where `in_valid` was low.
- R11: Op codes 10 to 15 drive `wr_en` low and `result` to zero, and copy `ccr_in` unchanged to `ccr_out`.
- R12: While `rst` is high at a clock edge, `out_valid`, `wr_en`, `result` and `ccr_out` clear to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| size | input | 2 | Width code |
| opa | input | 32 | First operand (destination side) |
| opb | input | 32 | Second operand (source side) |
| ccr_in | input | 8 | Current condition-code byte |
| out_valid | output | 1 | Registered result valid |
| wr_en | output | 1 | Result must be stored |
| result | output | 32 | Zero-extended result |
| ccr_out | output | 8 | Updated condition-code byte |

## Verification
The overflow and carry corners are hard to reach because each one needs an exact operand value at one width. These are the most negative value for negate and decrement, the largest positive value for increment, and a carry out of exactly bit 8, 16 or 32 for add. Only a few random draws would hit them by chance. The stimulus therefore aims directed operands at each width, and does so with `ccr_in[0]` both set and clear to show that the carry is kept. Some of these operands also carry non-zero bits above the selected width, so that any leak from the upper bits shows up in the flags. A random run over all codes and sizes follows, and a bench-side model predicts each response.

// File: rtl/alu_ccgen_pkg.sv
`timescale 1ns/1ps
package alu_ccgen_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_NEG = 4'd2,
    OP_CMP = 4'd3,
    OP_INC = 4'd4,
    OP_DEC = 4'd5,
    OP_AND = 4'd6,
    OP_OR  = 4'd7,
    OP_XOR = 4'd8,
    OP_NOT = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

  localparam int NUM_LANES = 3;
endpackage

// File: rtl/alu_lane.sv
`timescale 1ns/1ps
module alu_lane
  import alu_ccgen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] res,
  output nzvc_t        fl
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = ~MOST_NEG;
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W:0] sum_x, dif_x, neg_x;
  logic       v_r, c_r;

  always_comb begin
    sum_x = {1'b0, a} + {1'b0, b};
    dif_x = {1'b0, a} - {1'b0, b};
    neg_x = {(W+1){1'b0}} - {1'b0, a};
    res   = '0;
    v_r   = 1'b0;
    c_r   = c_in;
    case (alu_op_e'(op))
      OP_ADD: begin
        res = sum_x[W-1:0];
        c_r = sum_x[W];
        v_r = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
      end
      OP_SUB, OP_CMP: begin
        res = dif_x[W-1:0];
        c_r = dif_x[W];
        v_r = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
      end
      OP_NEG: begin
        res = neg_x[W-1:0];
        c_r = neg_x[W];
        v_r = (a == MOST_NEG);
      end
      OP_INC: begin
        res = a + ONE;
        v_r = (a == MOST_POS);
      end
      OP_DEC: begin
        res = a - ONE;
        v_r = (a == MOST_NEG);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_NOT: res = ~a;
      default: res = '0;
    endcase
    fl.n = res[W-1];
    fl.z = (res == '0);
    fl.v = v_r;
    fl.c = c_r;
  end
endmodule

// File: rtl/alu_select.sv
`timescale 1ns/1ps
module alu_select
  import alu_ccgen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]                          op,
  input  logic [1:0]                          size,
  input  logic [7:0]                          ccr_in,
  input  logic [NUM_LANES-1:0][DATA_W-1:0]    lane_res,
  input  logic [NUM_LANES-1:0][3:0]           lane_fl,
  output logic [DATA_W-1:0]                   nxt_res,
  output logic                                nxt_wr,
  output logic [7:0]                          nxt_ccr
);
  localparam logic [3:0] LAST_OP = 4'(OP_NOT);

  logic [1:0] idx;
  logic       legal;

  always_comb begin
    idx   = (size == 2'd3) ? 2'd2 : size;
    legal = (op <= LAST_OP);
    if (legal) begin
      nxt_res = lane_res[idx];
      nxt_ccr = {ccr_in[7:4], lane_fl[idx]};
      nxt_wr  = (op != 4'(OP_CMP));
    end else begin
      nxt_res = '0;
      nxt_ccr = ccr_in;
      nxt_wr  = 1'b0;
    end
  end
endmodule

// File: rtl/alu_ccgen.sv
`timescale 1ns/1ps
module alu_ccgen
  import alu_ccgen_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [7:0]        ccr_in,
  output logic              out_valid,
  output logic              wr_en,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        ccr_out
);
  logic [NUM_LANES-1:0][DATA_W-1:0] lane_res;
  logic [NUM_LANES-1:0][3:0]        lane_fl;
  logic [DATA_W-1:0]                nxt_res;
  logic                             nxt_wr;
  logic [7:0]                       nxt_ccr;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = DATA_W >> (NUM_LANES - 1 - g);
    logic [LW-1:0] r;
    nzvc_t         f;
    alu_lane #(.W(LW)) u_lane (
      .op  (op),
      .a   (opa[LW-1:0]),
      .b   (opb[LW-1:0]),
      .c_in(ccr_in[0]),
      .res (r),
      .fl  (f)
    );
    assign lane_res[g] = DATA_W'(r);
    assign lane_fl[g]  = f;
  end

  alu_select #(.DATA_W(DATA_W)) u_sel (
    .op      (op),
    .size    (size),
    .ccr_in  (ccr_in),
    .lane_res(lane_res),
    .lane_fl (lane_fl),
    .nxt_res (nxt_res),
    .nxt_wr  (nxt_wr),
    .nxt_ccr (nxt_ccr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      ccr_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wr_en   <= nxt_wr;
        result  <= nxt_res;
        ccr_out <= nxt_ccr;
      end else begin
        wr_en   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/alu_ccgen_chk.sv
`timescale 1ns/1ps
module alu_ccgen_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] opa,
  input logic [7:0]        ccr_in,
  input logic              out_valid,
  input logic              wr_en,
  input logic [DATA_W-1:0] result,
  input logic [7:0]        ccr_out
);
  p_zero_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op <= 4'd9) |=> (ccr_out[2] == (result == '0)));

  p_upper_bits_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (ccr_out[7:4] == $past(ccr_in[7:4])));

  p_neg_min_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd2 && size == 2'd0 && opa[7:0] == 8'h80) |=> ccr_out[1]);

  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd3) |=> (out_valid && !wr_en));

  p_carry_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 4'd4 || op == 4'd5)) |=> (ccr_out[0] == $past(ccr_in[0])));

  p_logic_v_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd6 && op <= 4'd9) |=> !ccr_out[1]);

  p_byte_zext_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == 2'd0) |=> (result[DATA_W-1:8] == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !wr_en);

  p_bad_op_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 4'd9) |=> (!wr_en && ccr_out == $past(ccr_in) && result == '0));
endmodule

bind alu_ccgen alu_ccgen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op       (op),
  .size     (size),
  .opa      (opa),
  .ccr_in   (ccr_in),
  .out_valid(out_valid),
  .wr_en    (wr_en),
  .result   (result),
  .ccr_out  (ccr_out)
);

// File: tb/sim_alu_ccgen.sv
`timescale 1ns/1ps
module sim_alu_ccgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [7:0]  ccr_in = '0;
  logic        out_valid, wr_en;
  logic [31:0] result;
  logic [7:0]  ccr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic        wr;
    logic [7:0]  cc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  alu_ccgen u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size(size),
    .opa(opa), .opb(opb), .ccr_in(ccr_in), .out_valid(out_valid),
    .wr_en(wr_en), .result(result), .ccr_out(ccr_out)
  );

  function automatic exp_t model(input logic [3:0] o, input logic [1:0] s,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [7:0] cc);
    exp_t e;
    int w;
    logic [63:0] mask, sbit, am, bm, r;
    logic n, z, v, c;
    w    = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    mask = (64'd1 << w) - 64'd1;
    sbit = 64'd1 << (w - 1);
    am   = {32'd0, a} & mask;
    bm   = {32'd0, b} & mask;
    v    = 1'b0;
    c    = cc[0];
    r    = 64'd0;
    case (o)
      4'd0: begin r = am + bm; c = r[w]; r = r & mask;
                  v = ((am ^ r) & (bm ^ r) & sbit) != 0; end
      4'd1, 4'd3: begin c = am < bm; r = (am - bm) & mask;
                  v = ((am ^ bm) & (am ^ r) & sbit) != 0; end
      4'd2: begin r = (64'd0 - am) & mask; c = am != 0; v = am == sbit; end
      4'd4: begin r = (am + 64'd1) & mask; v = am == (sbit - 64'd1); end
      4'd5: begin r = (am - 64'd1) & mask; v = am == sbit; end
      4'd6: r = am & bm;
      4'd7: r = am | bm;
      4'd8: r = am ^ bm;
      4'd9: r = ~am & mask;
      default: r = 64'd0;
    endcase
    n = (r & sbit) != 0;
    z = r == 0;
    e.r  = r[31:0];
    if (o > 4'd9) begin
      e.wr = 1'b0;
      e.cc = cc;
    end else begin
      e.wr = (o != 4'd3);
      e.cc = {cc[7:4], n, z, v, c};
    end
    e.tag = "";
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [1:0] s,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] cc, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op = o; size = s; opa = a; opb = b; ccr_in = cc;
    e = model(o, s, a, b, cc);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid === 1'b1) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R10: unexpected out_valid, actual 1 expected 0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (result !== e.r || wr_en !== e.wr || ccr_out !== e.cc) begin
            errors++;
            $display("FAIL %s: result %h/%h wr_en %b/%b ccr %h/%h (actual/expected)",
                     e.tag, result, e.r, wr_en, e.wr, ccr_out, e.cc);
          end
        end
      end else begin
        checks++;
        if (wr_en !== 1'b0) begin
          errors++;
          $display("FAIL R10: idle wr_en actual %b expected 0", wr_en);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // preload outputs with activity, then reset (R12)
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive(4'd0, 2'd2, 32'hFFFF_FFFF, 32'h1234_5678, 8'hF0, "R12 pre");
    idle(1);
    @(negedge clk);
    rst = 1'b1;
    void'(sb.pop_front());
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || result !== 32'd0 || ccr_out !== 8'd0) begin
      errors++;
      $display("FAIL R12: v%b w%b r%h c%h actual, expected all zero",
               out_valid, wr_en, result, ccr_out);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1 / R2 add corners
    drive(4'd0, 2'd0, 32'h7F, 32'h01, 8'hA0, "R1 R2 add8 overflow");
    drive(4'd0, 2'd0, 32'hFF, 32'h01, 8'h50, "R2 add8 carry zero");
    drive(4'd0, 2'd1, 32'hFFFF, 32'h0001, 8'h00, "R2 add16 carry bit16");
    drive(4'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 8'h00, "R2 add32 v c z");
    drive(4'd0, 2'd1, 32'h1234, 32'h4321, 8'h0F, "R2 add16 plain");
    // R3 subtract
    drive(4'd1, 2'd0, 32'h00, 32'h01, 8'h00, "R3 sub8 borrow");
    drive(4'd1, 2'd0, 32'h80, 32'h01, 8'h00, "R3 sub8 overflow");
    drive(4'd1, 2'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 8'h00, "R3 sub32 overflow");
    // R4 negate
    drive(4'd2, 2'd0, 32'h80, 32'h55, 8'h00, "R4 neg8 min");
    drive(4'd2, 2'd1, 32'h0000, 32'hFFFF, 8'h0F, "R4 neg16 zero");
    drive(4'd2, 2'd2, 32'h8000_0000, 32'h0, 8'h00, "R4 neg32 min");
    drive(4'd2, 2'd1, 32'h0001, 32'h0, 8'h00, "R4 neg16 one");
    // R5 compare
    drive(4'd3, 2'd0, 32'h42, 32'h42, 8'h00, "R5 cmp equal");
    drive(4'd3, 2'd1, 32'h0001, 32'h8000, 8'h00, "R5 cmp16 overflow");
    // R6 increment keeps carry
    drive(4'd4, 2'd0, 32'h7F, 32'h0, 8'h01, "R6 inc8 max pos c1");
    drive(4'd4, 2'd0, 32'h7F, 32'h0, 8'h00, "R6 inc8 max pos c0");
    drive(4'd4, 2'd1, 32'hFFFF, 32'h0, 8'h01, "R6 inc16 wrap");
    drive(4'd4, 2'd2, 32'h7FFF_FFFF, 32'h0, 8'h00, "R6 inc32 max pos");
    // R7 decrement
    drive(4'd5, 2'd0, 32'h80, 32'h0, 8'h01, "R7 dec8 min");
    drive(4'd5, 2'd2, 32'h0, 32'h0, 8'h00, "R7 dec32 zero");
    drive(4'd5, 2'd1, 32'h8000, 32'h0, 8'h00, "R7 dec16 min");
    // R8 logic
    drive(4'd6, 2'd0, 32'hF0, 32'h0F, 8'h03, "R8 and zero");
    drive(4'd7, 2'd1, 32'h8000, 32'h0001, 8'h02, "R8 or neg");
    drive(4'd8, 2'd2, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 8'h01, "R8 xor");
    drive(4'd9, 2'd0, 32'hFF, 32'h0, 8'h01, "R8 not zero");
    // R9 width handling
    drive(4'd0, 2'd0, 32'hABCD_12FF, 32'h9876_0001, 8'h00, "R9 upper ignored");
    drive(4'd9, 2'd1, 32'hFFFF_0000, 32'h0, 8'h00, "R9 not16 zext");
    drive(4'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 8'h00, "R9 size3 is 32");
    // R11 illegal
    drive(4'd10, 2'd0, 32'h12, 32'h34, 8'h5A, "R11 illegal 10");
    drive(4'd15, 2'd2, 32'hFFFF_FFFF, 32'h1, 8'hC3, "R11 illegal 15");
    // R10 gap
    idle(3);
    drive(4'd0, 2'd0, 32'h01, 32'h01, 8'h00, "R10 after gap");
    idle(1);
    // random mix
    for (int k = 0; k < 400; k++) begin
      drive(4'($urandom), 2'($urandom), $urandom, $urandom, 8'($urandom), "R9 random mix");
      if ((k % 37) == 0) idle(1);
    end
    idle(4);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10: pending results actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule